// File: doc/BRIEF.md
# Bit-Serial CRC Encoder and Frame Checker

This block computes a cyclic redundancy check one bit per clock. It has a left-shifting remainder register with XOR taps set by a divisor polynomial. The default divisor is X^5 + X^4 + X^2 + 1, written as the pattern 110101.

In encode mode, message bits arrive most significant bit first. Each bit is copied to the serial output while it is also folded into the divider. A strobe marks the last message bit. After that bit, the feedback path is gated off and the register becomes a plain shift register. It then pushes its five stored bits out behind the message, and those bits form the frame check sequence.

In verify mode, the whole received frame, including its check bits, goes through the same divider. When the final bit has been taken, the block raises a done flag. It also raises a pass flag if the remainder left in the register is zero. A one-cycle clear pulse empties the register, drops both flags and latches the mode for the next frame.

Top module: `crc_serial_unit`

## Requirements
- R1: While rst_n is low at a clock edge, every output is driven to 0 from the next cycle on: ser_o, ser_vld_o, done_o and pass_o.
- R2: In encode mode (mode latched as 0), each accepted message bit appears on ser_o with ser_vld_o high in the cycle after it is taken. A bit is accepted when bit_vld_i is high before the last-bit strobe.
- R3: In encode mode, the W cycles that follow the last message bit carry the frame check sequence, most significant bit first. It equals the remainder of message·x^W divided by the divisor, with 110101 as the default. For example, message 1010001101 gives 01110.
- R4: In encode mode, done_o rises in the same cycle in which the final check bit is presented. In the cycle after that, ser_vld_o is low and done_o stays high.
- R5: In verify mode, done_o rises in the cycle after the bit marked by last_i is taken. At the same time, pass_o is 1 if the complete frame leaves a zero remainder. ser_vld_o stays 0 throughout verify mode.
- R6: In verify mode, a frame whose remainder is nonzero gives done_o=1 with pass_o=0. This includes any frame with a single bit flipped.
- R7: A clear_i pulse empties the remainder register and drops done_o, pass_o and ser_vld_o in the next cycle. It also latches mode_i (0 = encode, 1 = verify). Changes on mode_i later in the frame have no effect.
- R8: Three kinds of input are ignored: a cycle with bit_vld_i low, any input during check-bit emission, and any input after done_o. None of them moves the remainder or changes the output stream.
- R9: Once set, done_o and pass_o hold their values until the next clear_i pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Start-of-frame clear; also latches mode_i |
| mode_i | input | 1 | 0 = encode, 1 = verify |
| bit_i | input | 1 | Serial input bit |
| bit_vld_i | input | 1 | bit_i is valid this cycle |
| last_i | input | 1 | Marks the final message bit (encode) or final frame bit (verify) |
| ser_o | output | 1 | Serial output: message bits, then check bits |
| ser_vld_o | output | 1 | ser_o carries a frame bit |
| done_o | output | 1 | Frame finished |
| pass_o | output | 1 | Verify result: zero remainder |

## Verification
The bench uses the default parameters: a five-bit register and the divisor 110101. With these values, all 1024 ten-bit messages can be swept. Each message is encoded and its check bits are compared with a remainder that the bench finds by long division. The resulting fifteen-bit frame is then verified both intact and with one bit flipped at a position that varies per message. Idle gaps, junk input during check-bit emission and after completion, and mode_i toggling within a frame are mixed into the sweep. Together these cover the ignore, hold and latch rules.

// File: rtl/crc_pkg.sv
// Shared types for the bit-serial CRC unit.
// Assumes: one frame at a time; phases advance only forward until a clear.
package crc_pkg;
    typedef enum logic [1:0] {
        PH_DATA = 2'd0,
        PH_FCS  = 2'd1,
        PH_DONE = 2'd2
    } crc_phase_t;
endpackage

// File: rtl/crc_shift_div.sv
// Remainder register of the serial divider. Shifts left by one when
// shift_i is high. With fb_en_i high, it folds (msb ^ din) into the stages
// whose divisor bit is set. With fb_en_i low, it only shifts zeros in.
// Assumes: POLY holds the divisor without its leading x^W term.
module crc_shift_div #(
    parameter int          W    = 5,
    parameter logic [W-1:0] POLY = 5'b10101
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         fb_en_i,
    input  logic         din_i,
    output logic [W-1:0] rem_q,
    output logic [W-1:0] rem_nxt
);
    logic fb;

    // Feedback bit: top stage combined with the incoming bit, gated by phase
    always_comb fb = fb_en_i ? (rem_q[W-1] ^ din_i) : 1'b0;

    // One XOR per divisor term, chained into the next-state vector
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_lsb
            assign rem_nxt[i] = fb & POLY[i];
        end else begin : g_upper
            assign rem_nxt[i] = rem_q[i-1] ^ (fb & POLY[i]);
        end
    end

    // Remainder register update
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            rem_q <= '0;
        else if (shift_i)
            rem_q <= rem_nxt;
    end

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !shift_i) |=> $stable(rem_q));
    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (rem_q == '0));
endmodule

// File: rtl/crc_ctrl.sv
// Frame sequencer. Latches the mode at clear and walks the phases
// data -> check bits -> done in encode mode, or data -> done in verify mode.
// It holds the done and pass flags until the next clear.
// Assumes: last_i is honoured only together with bit_vld_i.
module crc_ctrl
    import crc_pkg::*;
#(
    parameter int W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       mode_i,
    input  logic       bit_vld_i,
    input  logic       last_i,
    input  logic       rem_zero_nxt_i,
    output crc_phase_t phase_o,
    output logic       verify_o,
    output logic       shift_o,
    output logic       fb_en_o,
    output logic       done_o,
    output logic       pass_o
);
    localparam int CNT_W = $clog2(W) + 1;

    logic [CNT_W-1:0] cnt;

    // Divider control from the current phase
    always_comb begin
        shift_o = ((phase_o == PH_DATA) && bit_vld_i) || (phase_o == PH_FCS);
        fb_en_o = (phase_o == PH_DATA);
    end

    // Phase, check-bit counter, latched mode and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o  <= PH_DATA;
            cnt      <= '0;
            verify_o <= 1'b0;
            done_o   <= 1'b0;
            pass_o   <= 1'b0;
        end else if (clr_i) begin
            phase_o  <= PH_DATA;
            cnt      <= '0;
            verify_o <= mode_i;
            done_o   <= 1'b0;
            pass_o   <= 1'b0;
        end else begin
            case (phase_o)
                PH_DATA: if (bit_vld_i && last_i) begin
                    if (verify_o) begin
                        phase_o <= PH_DONE;
                        done_o  <= 1'b1;
                        pass_o  <= rem_zero_nxt_i;
                    end else begin
                        phase_o <= PH_FCS;
                        cnt     <= '0;
                    end
                end
                PH_FCS: if (cnt == CNT_W'(W - 1)) begin
                    phase_o <= PH_DONE;
                    done_o  <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> done_o);
    assert_pass_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> $stable(pass_o));
    assert_pass_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> done_o);
    assert_fcs_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(W));
endmodule

// File: rtl/crc_serial_unit.sv
// Bit-serial CRC encoder / frame checker top level. It joins the divider
// with the sequencer and registers the serial output: message bits pass
// through during the data phase, and the top register stage is emitted
// during the check-bit phase.
// Assumes: a clear pulse precedes every frame.
module crc_serial_unit
    import crc_pkg::*;
#(
    parameter int           W    = 5,
    parameter logic [W-1:0] POLY = 5'b10101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic mode_i,
    input  logic bit_i,
    input  logic bit_vld_i,
    input  logic last_i,
    output logic ser_o,
    output logic ser_vld_o,
    output logic done_o,
    output logic pass_o
);
    crc_phase_t   phase;
    logic         verify;
    logic         shift;
    logic         fb_en;
    logic [W-1:0] rem_q;
    logic [W-1:0] rem_nxt;
    logic         rem_zero_nxt;

    // Zero-remainder test on the value the register is about to take
    always_comb rem_zero_nxt = (rem_nxt == '0);

    crc_shift_div #(.W(W), .POLY(POLY)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clear_i),
        .shift_i (shift),
        .fb_en_i (fb_en),
        .din_i   (bit_i),
        .rem_q   (rem_q),
        .rem_nxt (rem_nxt)
    );

    crc_ctrl #(.W(W)) i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_i          (clear_i),
        .mode_i         (mode_i),
        .bit_vld_i      (bit_vld_i),
        .last_i         (last_i),
        .rem_zero_nxt_i (rem_zero_nxt),
        .phase_o        (phase),
        .verify_o       (verify),
        .shift_o        (shift),
        .fb_en_o        (fb_en),
        .done_o         (done_o),
        .pass_o         (pass_o)
    );

    // Serial output register: pass-through in data phase, check bits after
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ser_o     <= 1'b0;
            ser_vld_o <= 1'b0;
        end else if (!verify && phase == PH_DATA && bit_vld_i) begin
            ser_o     <= bit_i;
            ser_vld_o <= 1'b1;
        end else if (phase == PH_FCS) begin
            ser_o     <= rem_q[W-1];
            ser_vld_o <= 1'b1;
        end else begin
            ser_o     <= 1'b0;
            ser_vld_o <= 1'b0;
        end
    end

    assert_ser_follows_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !verify && phase == PH_DATA && bit_vld_i)
        |=> (ser_vld_o && ser_o == $past(bit_i)));
    assert_no_output_in_verify_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (verify && !clear_i) |=> !ser_vld_o);
    assert_quiet_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && !clear_i) |=> !ser_vld_o);
endmodule

// File: tb/test_crc_serial_unit.sv
// Sweeps every 10-bit message through encode, then verifies the produced
// frame intact and with one bit flipped. Expected values come from long
// division in the bench.
module test_crc_serial_unit;
    localparam int W = 5;
    localparam logic [31:0] DIVISOR = 32'b110101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 1'b0;
    logic mode_i = 1'b0;
    logic bit_i = 1'b0;
    logic bit_vld_i = 1'b0;
    logic last_i = 1'b0;
    logic ser_o, ser_vld_o, done_o, pass_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    crc_serial_unit i_crc_serial_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .mode_i    (mode_i),
        .bit_i     (bit_i),
        .bit_vld_i (bit_vld_i),
        .last_i    (last_i),
        .ser_o     (ser_o),
        .ser_vld_o (ser_vld_o),
        .done_o    (done_o),
        .pass_o    (pass_o)
    );

    function automatic logic [W-1:0] mod_rem(input logic [31:0] v, input int nb);
        for (int i = nb - 1; i >= W; i--)
            if (v[i]) v = v ^ (DIVISOR << (i - W));
        return v[W-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_clear(input logic m);
        clear_i = 1'b1; mode_i = m; bit_vld_i = 1'b0; last_i = 1'b0;
        @(negedge clk);
        clear_i = 1'b0;
        mode_i = ~m; // R7: later mode changes must not matter
        chk(!done_o && !pass_o && !ser_vld_o, "R7 clear",
            {done_o, pass_o, ser_vld_o}, 0);
    endtask

    task automatic run_gen(input logic [9:0] m, input bit gaps, input bit junk,
                           output logic [14:0] frame);
        logic [W-1:0] fcs;
        fcs = mod_rem({17'd0, m, 5'd0}, 15);
        frame = {m, fcs};
        do_clear(1'b0);
        for (int i = 9; i >= 0; i--) begin
            if (gaps && (i % 3 == 1)) begin
                bit_vld_i = 1'b0; bit_i = 1'b1; last_i = 1'b1;
                @(negedge clk);
                chk(!ser_vld_o, "R8 idle gap encode", ser_vld_o, 0);
            end
            bit_vld_i = 1'b1; bit_i = m[i]; last_i = (i == 0);
            @(negedge clk);
            chk(ser_vld_o && ser_o == m[i], "R2 pass-through",
                {ser_vld_o, ser_o}, {1'b1, m[i]});
        end
        bit_vld_i = junk; bit_i = 1'b1; last_i = junk;
        for (int j = W - 1; j >= 0; j--) begin
            @(negedge clk);
            chk(ser_vld_o && ser_o == fcs[j], "R3 check bit",
                {ser_vld_o, ser_o}, {1'b1, fcs[j]});
            chk(done_o == (j == 0), "R4 done timing", done_o, (j == 0));
        end
        @(negedge clk);
        chk(!ser_vld_o && done_o, "R4 after check bits", {ser_vld_o, done_o}, 1);
        bit_vld_i = 1'b0; last_i = 1'b0;
    endtask

    task automatic run_chk(input logic [14:0] f, input bit gaps);
        logic expp;
        expp = (mod_rem({17'd0, f}, 15) == '0);
        do_clear(1'b1);
        for (int i = 14; i >= 0; i--) begin
            if (gaps && (i % 4 == 2)) begin
                bit_vld_i = 1'b0; bit_i = 1'b1; last_i = 1'b1;
                @(negedge clk);
                chk(!done_o && !ser_vld_o, "R8 idle gap verify", {done_o, ser_vld_o}, 0);
            end
            bit_vld_i = 1'b1; bit_i = f[i]; last_i = (i == 0);
            @(negedge clk);
            chk(done_o == (i == 0) && !ser_vld_o, "R5 done timing",
                {done_o, ser_vld_o}, {(i == 0), 1'b0});
        end
        chk(pass_o == expp, expp ? "R5 pass" : "R6 error detected", pass_o, expp);
        bit_vld_i = 1'b1; bit_i = 1'b1; last_i = 1'b1;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(done_o && pass_o == expp, "R9 flags hold", {done_o, pass_o}, {1'b1, expp});
        end
        bit_vld_i = 1'b0; last_i = 1'b0;
    endtask

    initial begin
        logic [14:0] fr;
        repeat (3) @(negedge clk);
        chk(!ser_o && !ser_vld_o && !done_o && !pass_o, "R1 reset",
            {ser_o, ser_vld_o, done_o, pass_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 worked example
        run_gen(10'b1010001101, 1'b0, 1'b0, fr);
        chk(fr == 15'b101000110101110, "R3 example frame", fr, 15'b101000110101110);
        for (int m = 0; m < 1024; m++) begin
            run_gen(m[9:0], m[0], m[1], fr);
            run_chk(fr, m[2]);
            run_chk(fr ^ (15'd1 << (m % 15)), m[3]); // R6 single-bit flip
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule